// File: doc/BRIEF.md
# CAN message buffer status flags

This block keeps the per-buffer status state for a bank of CAN message buffers (32 by default). Every buffer carries three flags: ready, transmit request and message updated. Software reads each buffer's flags as one status byte. It can only change them through a separate set/clear port, which takes a set mask and a clear mask in a single word. There is no path that writes the status byte directly.

The protocol engine reports three kinds of event, each as a one-cycle pulse with a buffer index: a data frame was received, a remote frame was received, or a transmission completed. From these events the block updates the update flag and the request flag, and it pulses an overwrite indication that goes to the buffer's control register. For each buffer it also reports whether the buffer may transmit, whether it may receive, and whether it is a receive-type buffer asking for a remote frame. The buffer type (transmit or receive) is an input supplied by the control logic.

Top module: `can_msgbuf_flags`

## Requirements
- R1: The status byte read for a buffer has the ready flag in bit 0, the transmit-request flag in bit 1 and the update flag in bit 2; bits 7 to 3 always read 0. After reset every flag of every buffer is 0.
- R2: A set/clear write to buffer k takes its set mask from bits 10:8 and its clear mask from bits 2:0, one mask bit per flag position of R1. A bit present in both masks ends up set. All other word bits have no effect, and no buffer other than k changes. The new value is readable after the next clock edge.
- R3: tx_perm_o bit k is 1 exactly when buffer k has both the ready flag and the request flag at 1.
- R4: rx_perm_o bit k equals buffer k's ready flag. A received-frame event for a buffer whose ready flag is 0 changes no flag and gives no overwrite pulse.
- R5: A received-frame event for a ready buffer sets its update flag from the next clock edge.
- R6: A received-frame event for a ready buffer whose update flag is already 1 raises that buffer's bit of ovr_o for exactly one cycle after the edge, and the update flag stays 1.
- R7: A remote-frame event sets the update flag only for a ready buffer marked as transmit type. On a receive-type or non-ready buffer it has no effect.
- R8: A transmission-completed event for buffer k clears its update flag and its request flag and leaves its ready flag unchanged.
- R9: rtr_req_o bit k is 1 exactly when buffer k is of receive type with ready and request both 1.
- R10: When a hardware event and a set/clear write hit the same buffer in the same cycle, the event decides the flags it touches and the write applies to the remaining flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_idx_i | input | 5 | Buffer whose status byte is read |
| rd_data_o | output | 8 | Status byte of the selected buffer |
| sc_we_i | input | 1 | Set/clear write strobe |
| sc_idx_i | input | 5 | Buffer addressed by the set/clear write |
| sc_wdata_i | input | 16 | Set mask in 10:8, clear mask in 2:0 |
| rx_ev_i | input | 1 | Data frame received pulse |
| rx_idx_i | input | 5 | Buffer of the received frame |
| rtr_ev_i | input | 1 | Remote frame received pulse |
| rtr_idx_i | input | 5 | Buffer of the remote frame |
| tx_done_i | input | 1 | Transmission completed pulse |
| tx_idx_i | input | 5 | Buffer that completed transmission |
| buf_is_tx_i | input | 32 | Per-buffer type, 1 = transmit buffer |
| tx_perm_o | output | 32 | Buffer may transmit |
| rx_perm_o | output | 32 | Buffer may receive |
| rtr_req_o | output | 32 | Receive buffer requests a remote frame |
| ovr_o | output | 32 | One-cycle overwrite pulse per buffer |

## Verification
The bench sends a word with the same bit in both masks, which catches a design that lets clear win. It fills the unused word bits with ones, which catches any leak into the reserved byte bits. It sends a second frame into an already updated buffer, where a design with a wrong update path would miss the overwrite pulse, keep it high for longer than one cycle, or drop the update flag. A remote frame sent to a receive-type buffer and a data frame sent to a non-ready buffer must leave everything unchanged. Collisions between an event and a software write on the same buffer show whether the event really takes priority over the write on the flags it touches.

// File: rtl/can_flags_pkg.sv
package can_flags_pkg;
  localparam int unsigned FLAG_W = 3;
  localparam int unsigned SET_LSB = 8;

  typedef struct packed {
    logic dn;   // bit 2
    logic trq;  // bit 1
    logic rdy;  // bit 0
  } flags_t;
endpackage

// File: rtl/can_flag_dec.sv
module can_flag_dec #(
  parameter int unsigned NUM_BUF = 32,
  localparam int unsigned IDX_W = $clog2(NUM_BUF)
) (
  input  logic             vld_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [NUM_BUF-1:0] hit_o
);
  for (genvar g = 0; g < NUM_BUF; g++) begin : g_hit
    assign hit_o[g] = vld_i && (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/can_flag_cell.sv
module can_flag_cell
  import can_flags_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sw_we_i,
  input  flags_t sw_set_i,
  input  flags_t sw_clr_i,
  input  logic   rx_hit_i,
  input  logic   rtr_hit_i,
  input  logic   tx_done_i,
  input  logic   is_tx_i,
  output flags_t flags_o,
  output logic   ovr_o
);
  flags_t q, d, sw_d;
  logic rx_acc, rtr_acc;

  assign rx_acc  = rx_hit_i && q.rdy;
  assign rtr_acc = rtr_hit_i && q.rdy && is_tx_i;

  always_comb begin
    sw_d = sw_we_i ? flags_t'((q & ~sw_clr_i) | sw_set_i) : q;
    d = sw_d;
    // hardware events override software on the flags they touch
    if (tx_done_i) begin
      d.trq = 1'b0;
      d.dn  = 1'b0;
    end
    if (rx_acc || rtr_acc) d.dn = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q     <= '0;
      ovr_o <= 1'b0;
    end else begin
      q     <= d;
      ovr_o <= rx_acc && q.dn;
    end
  end

  assign flags_o = q;
endmodule

// File: rtl/can_flag_rdmux.sv
module can_flag_rdmux
  import can_flags_pkg::*;
#(
  parameter int unsigned NUM_BUF = 32,
  localparam int unsigned IDX_W = $clog2(NUM_BUF)
) (
  input  flags_t           flags_i [NUM_BUF],
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       data_o
);
  flags_t sel;
  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_BUF; i++)
      if (idx_i == IDX_W'(i)) sel = flags_i[i];
  end
  // reserved bit and upper nibble read as zero
  assign data_o = {5'b0, sel};
endmodule

// File: rtl/can_msgbuf_flags.sv
module can_msgbuf_flags
  import can_flags_pkg::*;
#(
  parameter int unsigned NUM_BUF = 32,
  localparam int unsigned IDX_W = $clog2(NUM_BUF)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [7:0]         rd_data_o,
  input  logic               sc_we_i,
  input  logic [IDX_W-1:0]   sc_idx_i,
  input  logic [15:0]        sc_wdata_i,
  input  logic               rx_ev_i,
  input  logic [IDX_W-1:0]   rx_idx_i,
  input  logic               rtr_ev_i,
  input  logic [IDX_W-1:0]   rtr_idx_i,
  input  logic               tx_done_i,
  input  logic [IDX_W-1:0]   tx_idx_i,
  input  logic [NUM_BUF-1:0] buf_is_tx_i,
  output logic [NUM_BUF-1:0] tx_perm_o,
  output logic [NUM_BUF-1:0] rx_perm_o,
  output logic [NUM_BUF-1:0] rtr_req_o,
  output logic [NUM_BUF-1:0] ovr_o
);
  logic [NUM_BUF-1:0] sc_hit, rx_hit, rtr_hit, tx_hit;
  logic [NUM_BUF-1:0] dn_vec, trq_vec, rdy_vec;
  flags_t flags [NUM_BUF];
  flags_t set_m, clr_m;
  logic unused_wbits;

  assign set_m = sc_wdata_i[SET_LSB +: FLAG_W];
  assign clr_m = sc_wdata_i[FLAG_W-1:0];
  assign unused_wbits = ^{sc_wdata_i[15:SET_LSB+FLAG_W], sc_wdata_i[SET_LSB-1:FLAG_W]};

  can_flag_dec #(.NUM_BUF(NUM_BUF)) u_dec_sc  (.vld_i(sc_we_i),   .idx_i(sc_idx_i),  .hit_o(sc_hit));
  can_flag_dec #(.NUM_BUF(NUM_BUF)) u_dec_rx  (.vld_i(rx_ev_i),   .idx_i(rx_idx_i),  .hit_o(rx_hit));
  can_flag_dec #(.NUM_BUF(NUM_BUF)) u_dec_rtr (.vld_i(rtr_ev_i),  .idx_i(rtr_idx_i), .hit_o(rtr_hit));
  can_flag_dec #(.NUM_BUF(NUM_BUF)) u_dec_tx  (.vld_i(tx_done_i), .idx_i(tx_idx_i),  .hit_o(tx_hit));

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    can_flag_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sw_we_i   (sc_hit[g]),
      .sw_set_i  (set_m),
      .sw_clr_i  (clr_m),
      .rx_hit_i  (rx_hit[g]),
      .rtr_hit_i (rtr_hit[g]),
      .tx_done_i (tx_hit[g]),
      .is_tx_i   (buf_is_tx_i[g]),
      .flags_o   (flags[g]),
      .ovr_o     (ovr_o[g])
    );
    assign dn_vec[g]  = flags[g].dn;
    assign trq_vec[g] = flags[g].trq;
    assign rdy_vec[g] = flags[g].rdy;
  end

  assign tx_perm_o = rdy_vec & trq_vec;
  assign rx_perm_o = rdy_vec;
  assign rtr_req_o = rdy_vec & trq_vec & ~buf_is_tx_i;

  can_flag_rdmux #(.NUM_BUF(NUM_BUF)) u_rdmux (
    .flags_i (flags),
    .idx_i   (rd_idx_i),
    .data_o  (rd_data_o)
  );
endmodule

// File: rtl/can_flags_chk.sv
module can_flags_chk #(
  parameter int unsigned NUM_BUF = 32,
  localparam int unsigned IDX_W = $clog2(NUM_BUF)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rx_ev_i,
  input logic [IDX_W-1:0]   rx_idx_i,
  input logic               tx_done_i,
  input logic [IDX_W-1:0]   tx_idx_i,
  input logic [NUM_BUF-1:0] buf_is_tx_i,
  input logic [7:0]         rd_data_o,
  input logic [NUM_BUF-1:0] tx_perm_o,
  input logic [NUM_BUF-1:0] rx_perm_o,
  input logic [NUM_BUF-1:0] rtr_req_o,
  input logic [NUM_BUF-1:0] ovr_o,
  input logic [NUM_BUF-1:0] dn_vec,
  input logic [NUM_BUF-1:0] trq_vec
);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:3] == 5'b0);
  // R3
  tx_needs_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_perm_o & ~rx_perm_o) == '0);
  // R9
  rtr_rx_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rtr_req_o & (buf_is_tx_i | ~tx_perm_o)) == '0);
  // R5
  rx_sets_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ev_i && rx_perm_o[rx_idx_i] |=> dn_vec[$past(rx_idx_i)]);
  // R6
  ovr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o != '0 |-> $past(rx_ev_i) && $onehot(ovr_o));
  // R8
  tx_clears_trq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> !trq_vec[$past(tx_idx_i)]);
endmodule

bind can_msgbuf_flags can_flags_chk #(.NUM_BUF(NUM_BUF)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_ev_i(rx_ev_i), .rx_idx_i(rx_idx_i),
  .tx_done_i(tx_done_i), .tx_idx_i(tx_idx_i), .buf_is_tx_i(buf_is_tx_i),
  .rd_data_o(rd_data_o), .tx_perm_o(tx_perm_o), .rx_perm_o(rx_perm_o),
  .rtr_req_o(rtr_req_o), .ovr_o(ovr_o), .dn_vec(dn_vec), .trq_vec(trq_vec)
);

// File: tb/can_msgbuf_flags_tb_top.sv
`timescale 1ns/1ps
module can_msgbuf_flags_tb_top;
  localparam int NB = 32;
  logic clk = 0, rst_n = 0;
  logic [4:0] rd_idx = 0, sc_idx = 0, rx_idx = 0, rtr_idx = 0, tx_idx = 0;
  logic [7:0] rd_data;
  logic sc_we = 0, rx_ev = 0, rtr_ev = 0, tx_done = 0;
  logic [15:0] sc_wdata = 0;
  logic [NB-1:0] is_tx = 0, tx_perm, rx_perm, rtr_req, ovr;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  can_msgbuf_flags dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .sc_we_i(sc_we), .sc_idx_i(sc_idx), .sc_wdata_i(sc_wdata),
    .rx_ev_i(rx_ev), .rx_idx_i(rx_idx), .rtr_ev_i(rtr_ev), .rtr_idx_i(rtr_idx),
    .tx_done_i(tx_done), .tx_idx_i(tx_idx), .buf_is_tx_i(is_tx),
    .tx_perm_o(tx_perm), .rx_perm_o(rx_perm), .rtr_req_o(rtr_req), .ovr_o(ovr)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [7:0] v);
    rd_idx = 5'(idx); #0.5; v = rd_data;
  endtask

  // drive one cycle of stimulus from a negedge, return at the next negedge
  task automatic sc_wr(int idx, logic [15:0] w);
    sc_we = 1; sc_idx = 5'(idx); sc_wdata = w;
    @(negedge clk); sc_we = 0; sc_wdata = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int i = 0; i < NB; i++) begin rd(i, v); chk("R1 reset byte", 32'(v), 0); end
    chk("R3 reset tx_perm", tx_perm, 0);
    chk("R4 reset rx_perm", rx_perm, 0);
  endtask

  task automatic t_setclr;
    logic [7:0] v;
    sc_wr(3, 16'hFF_F8);               // set all, junk in clear byte above bit 2
    rd(3, v); chk("R1 R2 set all, reserved zero", 32'(v), 32'h07);
    rd(4, v); chk("R2 neighbour untouched", 32'(v), 0);
    sc_wr(3, 16'h0002);                // clear trq
    rd(3, v); chk("R2 clear trq", 32'(v), 32'h05);
    sc_wr(3, 16'h0202);                // trq in both masks: set wins
    rd(3, v); chk("R2 set wins", 32'(v), 32'h07);
    sc_wr(3, 16'h0007);
    rd(3, v); chk("R2 clear all", 32'(v), 0);
  endtask

  task automatic t_perm;
    is_tx = '0; is_tx[9] = 1'b1;
    sc_wr(7, 16'h0100);                // rdy only
    sc_wr(8, 16'h0300);                // rdy+trq, rx type
    sc_wr(9, 16'h0300);                // rdy+trq, tx type
    sc_wr(10, 16'h0200);               // trq only
    chk("R3 tx_perm", tx_perm, 32'h0000_0300);
    chk("R4 rx_perm", rx_perm, 32'h0000_0380);
    chk("R9 rtr_req", rtr_req, 32'h0000_0100);
    for (int i = 7; i <= 10; i++) sc_wr(i, 16'h0007);
  endtask

  task automatic t_rx;
    logic [7:0] v;
    rx_ev = 1; rx_idx = 12; @(negedge clk); rx_ev = 0;
    rd(12, v); chk("R4 rx ignored when not ready", 32'(v), 0);
    chk("R4 no ovr when not ready", ovr, 0);
    sc_wr(12, 16'h0100);
    rx_ev = 1; rx_idx = 12; @(negedge clk); rx_ev = 0;
    rd(12, v); chk("R5 dn set", 32'(v), 32'h05);
    chk("R6 no ovr on first frame", ovr, 0);
    rx_ev = 1; @(negedge clk); rx_ev = 0;
    chk("R6 ovr pulse", ovr, 32'h0000_1000);
    rd(12, v); chk("R6 dn stays", 32'(v), 32'h05);
    @(negedge clk);
    chk("R6 ovr one cycle", ovr, 0);
    sc_wr(12, 16'h0007);
  endtask

  task automatic t_remote;
    logic [7:0] v;
    is_tx = '0; is_tx[14] = 1'b1;
    sc_wr(14, 16'h0100); sc_wr(15, 16'h0100);
    rtr_ev = 1; rtr_idx = 15; @(negedge clk); rtr_ev = 0;
    rd(15, v); chk("R7 remote on rx buffer ignored", 32'(v), 32'h01);
    rtr_ev = 1; rtr_idx = 14; @(negedge clk); rtr_ev = 0;
    rd(14, v); chk("R7 remote sets dn", 32'(v), 32'h05);
    chk("R7 no ovr from remote", ovr, 0);
    sc_wr(14, 16'h0007); sc_wr(15, 16'h0007);
    is_tx = '0;
  endtask

  task automatic t_txdone;
    logic [7:0] v;
    sc_wr(20, 16'h0700);
    tx_done = 1; tx_idx = 20; @(negedge clk); tx_done = 0;
    rd(20, v); chk("R8 tx done clears dn trq", 32'(v), 32'h01);
    chk("R3 tx_perm drops after tx", tx_perm, 0);
    sc_wr(20, 16'h0007);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    // write sets everything while tx completes: trq/dn from hardware
    tx_done = 1; tx_idx = 5;
    sc_wr(5, 16'h0700); tx_done = 0;
    rd(5, v); chk("R10 tx done beats set", 32'(v), 32'h01);
    // write clears dn and sets trq while a frame arrives
    rx_ev = 1; rx_idx = 5;
    sc_wr(5, 16'h0204); rx_ev = 0;
    rd(5, v); chk("R10 rx beats clear", 32'(v), 32'h07);
    sc_wr(5, 16'h0007);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_setclr();
    t_perm();
    t_rx();
    t_remote();
    t_txdone();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule